// File: doc/BRIEF.md
# Digit-Serial Sticky Indicator for a Sequential Decimal Multiplier

This block forms the sticky indication that a sequential decimal multiplier needs for rounding. The wide intermediate product comes out of the multiplier one BCD digit per clock, least significant digit first. After normalisation, every digit that lies to the right of the guard and round digits must be folded into one sticky flag. The block does not wait for the whole product and then reduce a shifted vector. It keeps a running OR and a down-counter. The counter holds how many of the incoming low-order digits fall below the round position.

The multiplier control works out the digit count from the leading-zero counts of the two operands. The count is the significant product length, less the precision, less two for the guard and round digits. Control presents this count together with a start strobe. The block clamps a negative count to zero. From then on it folds in one valid digit per cycle until the counter empties. It then raises its done flag and holds the result still. This gives the rounding step a stable sticky value well ahead of the cycle in which rounding uses it. The block does not shift the product and does not round.

Top module: `sticky_serial_gen`

## Requirements
- R1: While reset is applied, and after it is released with no start yet, sticky_o and done_o are both 0.
- R2: A start strobe clears the sticky flag and loads the counter in the same clock edge. A digit presented in the start cycle is ignored, even when dig_vld_i is high. A start during an unfinished run abandons that run.
- R3: A negative skip count (two's complement, sign in the top bit) is clamped to zero. No digit is folded in, and done_o is 1 on the cycle after the start.
- R4: A skip count of zero gives sticky_o = 0 and done_o = 1 on the cycle after the start.
- R5: A digit counts as non-zero when any of its four bits is 1. A valid non-zero digit accepted while the counter is above zero sets sticky_o, and sticky_o then stays 1 until the next start.
- R6: Only cycles with dig_vld_i = 1 are accepted, and each one decrements the counter. Digits in invalid cycles, and digits after the count has run out, do not affect sticky_o.
- R7: Once done_o is 1, it stays 1 and sticky_o stays unchanged until the next start, whatever digits arrive.
- R8: For a count N > 0, done_o goes to 1 on the cycle after the clock edge that accepts the N-th valid digit.
- R9: While valid digits are still owed after a start with a positive count, done_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a new product: clears sticky, loads count |
| skip_cnt_i | input | CNT_W | Signed number of low-order digits below the round digit |
| dig_i | input | 4 | BCD product digit, least significant first |
| dig_vld_i | input | 1 | dig_i carries a digit this cycle |
| sticky_o | output | 1 | OR of all accepted low-order digits |
| done_o | output | 1 | All counted digits have been accepted; sticky_o is final |

## Verification
Two functions can fall in the same cycle. A start strobe for a new product can arrive while a valid digit is on the stream, and a start can also interrupt a run that is still counting. The bench provokes both. It drives a non-zero valid digit in the start cycle, and it restarts a run after a non-zero digit has already set sticky. The result is judged by the sticky value and done timing of the new run, which the scoreboard computes with the start-cycle digit left out. The bench also feeds non-zero digits after the count has run out and confirms that the held result does not move.

// File: rtl/sticky_pkg.sv
package sticky_pkg;
    localparam int DIG_W = 4;
    typedef logic [DIG_W-1:0] bcd_t;
endpackage

// File: rtl/sticky_digit_nz.sv
module sticky_digit_nz #(
    parameter int W = 4
) (
    input  logic [W-1:0] dig_i,
    output logic         nz_o
);
    logic [W:0] acc;

    assign acc[0] = 1'b0;
    for (genvar g = 0; g < W; g++) begin : g_or
        assign acc[g+1] = acc[g] | dig_i[g];
    end
    assign nz_o = acc[W];
endmodule

// File: rtl/sticky_cnt_clamp.sv
module sticky_cnt_clamp #(
    parameter int CNT_W = 6,
    localparam int UW = CNT_W - 1
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic [UW-1:0]    cnt_o
);
    // sign bit set: nothing lies below the round digit
    assign cnt_o = cnt_i[CNT_W-1] ? '0 : cnt_i[UW-1:0];
endmodule

// File: rtl/sticky_serial_gen.sv
module sticky_serial_gen
    import sticky_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] skip_cnt_i,
    input  logic [3:0]       dig_i,
    input  logic             dig_vld_i,
    output logic             sticky_o,
    output logic             done_o
);
    localparam int UW = CNT_W - 1;

    typedef struct packed {
        logic [UW-1:0] left;
        logic          sticky;
        logic          done;
    } st_t;

    st_t           st_d, st_q;
    logic [UW-1:0] load_cnt;
    logic          dig_nz;
    logic          take;
    bcd_t          dig_b;

    assign dig_b = dig_i;

    sticky_cnt_clamp #(.CNT_W(CNT_W)) u_clamp (
        .cnt_i (skip_cnt_i),
        .cnt_o (load_cnt)
    );

    sticky_digit_nz #(.W(DIG_W)) u_nz (
        .dig_i (dig_b),
        .nz_o  (dig_nz)
    );

    // a digit is accepted only outside a start cycle and while owed
    assign take = dig_vld_i && !start_i && (st_q.left != '0);

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.left   = load_cnt;
            st_d.sticky = 1'b0;
            st_d.done   = (load_cnt == '0);
        end else if (take) begin
            st_d.left   = st_q.left - 1'b1;
            st_d.sticky = st_q.sticky | dig_nz;
            st_d.done   = (st_q.left == UW'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sticky_o = st_q.sticky;
    assign done_o   = st_q.done;

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !sticky_o);

    assert_neg_count_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && skip_cnt_i[CNT_W-1]) |=> done_o);

    assert_zero_count_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && skip_cnt_i == '0) |=> (done_o && !sticky_o));

    assert_nonzero_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && dig_vld_i && !done_o && st_q.left != '0 && dig_i != 4'd0) |=> sticky_o);

    assert_sticky_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_o && !start_i) |=> sticky_o);

    assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(sticky_o)));

    assert_busy_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !skip_cnt_i[CNT_W-1] && skip_cnt_i != '0) |=> !done_o);
endmodule

// File: tb/sim_sticky_serial_gen.sv
`timescale 1ns/1ps
module sim_sticky_serial_gen;
    localparam int  CNT_W = 6;
    localparam real PER   = 5.0;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] count = '0;
    logic [3:0]       dig = '0;
    logic             vld = 1'b0;
    logic             sticky_o, done_o;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic  s;
        real   ts;
        real   td;
        string req;
    } exp_t;
    exp_t q[$];

    always #(PER/2) clk = ~clk;

    sticky_serial_gen #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .skip_cnt_i(count),
        .dig_i(dig), .dig_vld_i(vld), .sticky_o(sticky_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $realtime);
        end
    endtask

    // monitor: pops an expected result when done shows up
    always @(negedge clk) begin
        if (q.size() > 0 && done_o && $realtime >= q[0].ts + PER - 0.1) begin
            exp_t e;
            e = q.pop_front();
            chk(($realtime - e.td) < 0.1 && (e.td - $realtime) < 0.1, "R8 done time(ps)",
                int'($realtime * 1000.0), int'(e.td * 1000.0));
            chk(sticky_o == e.s, e.req, int'(sticky_o), int'(e.s));
        end
    end

    // driver: computes the expected result from the requirements
    task automatic run_case(input int cnt, input int nd, input logic [63:0] digs,
                            input logic [15:0] vlds, input logic [3:0] col_dig,
                            input bit push, input string req);
        int   k = (cnt < 0) ? 0 : cnt;
        int   taken = 0;
        int   last = -1;
        logic exp_s = 1'b0;
        real  t0;
        for (int i = 0; i < nd; i++) begin
            if (vlds[i] && taken < k) begin
                exp_s = exp_s | (digs[i*4 +: 4] != 4'd0);
                taken++;
                if (taken == k) last = i;
            end
        end
        @(negedge clk);
        t0    = $realtime;
        start = 1'b1;
        count = CNT_W'(cnt);
        vld   = (col_dig != 4'd0);
        dig   = col_dig;
        if (push) q.push_back('{exp_s, t0, t0 + PER * (last + 2), req});
        taken = 0;
        for (int i = 0; i < nd; i++) begin
            @(negedge clk);
            if (push && k > 0 && taken < k)
                chk(done_o == 1'b0, "R9 done while owed", int'(done_o), 0);
            start = 1'b0;
            vld   = vlds[i];
            dig   = digs[i*4 +: 4];
            if (vlds[i]) taken++;
        end
        if (push) begin
            for (int j = 0; j < 2; j++) begin
                @(negedge clk);
                start = 1'b0;
                vld   = 1'b1;
                dig   = 4'd9;
            end
        end
        @(negedge clk);
        start = 1'b0;
        vld   = 1'b0;
        dig   = 4'd0;
        if (push) begin
            chk(done_o == 1'b1, "R7 done held", int'(done_o), 1);
            chk(sticky_o == exp_s, "R7 sticky held", int'(sticky_o), int'(exp_s));
        end
    endtask

    initial begin
        #(PER * 100000);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PER * 2.25);
        chk(sticky_o == 1'b0 && done_o == 1'b0, "R1 in reset", int'({sticky_o, done_o}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(sticky_o == 1'b0 && done_o == 1'b0, "R1 idle", int'({sticky_o, done_o}), 0);
        // R6: a valid digit before any start is not accepted
        vld = 1'b1; dig = 4'd7;
        @(negedge clk);
        vld = 1'b0;
        chk(sticky_o == 1'b0 && done_o == 1'b0, "R6 before start", int'({sticky_o, done_o}), 0);

        run_case(3, 3, 64'h500, 16'h7, 4'd0, 1'b1, "R5 last digit set");
        run_case(4, 4, 64'h0, 16'hF, 4'd0, 1'b1, "R7 zeros then extras");
        run_case(-3, 3, 64'h999, 16'h7, 4'd0, 1'b1, "R3 negative count");
        run_case(0, 2, 64'h11, 16'h3, 4'd0, 1'b1, "R4 zero count");
        run_case(2, 3, 64'h070, 16'h5, 4'd0, 1'b1, "R6 invalid gap");
        run_case(2, 3, 64'h300, 16'h7, 4'd0, 1'b1, "R6 beyond count");
        run_case(2, 2, 64'h0, 16'h3, 4'd8, 1'b1, "R2 start-cycle digit");
        for (int b = 0; b < 4; b++)
            run_case(1, 1, 64'(4'(1 << b)), 16'h1, 4'd0, 1'b1, "R5 single bit");
        run_case(5, 2, 64'h42, 16'h3, 4'd0, 1'b0, "abort");
        run_case(2, 2, 64'h0, 16'h3, 4'd0, 1'b1, "R2 restart clears");
        run_case(14, 16, 64'h0000_1000_0000_0000, 16'hBFFF, 4'd0, 1'b1, "R6 long gap");
        run_case(31, 31 > 16 ? 16 : 31, 64'h0, 16'hFFFF, 4'd0, 1'b0, "long part");
        run_case(1, 1, 64'h0, 16'h1, 4'd0, 1'b1, "R2 restart long");

        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R8 all results seen", q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule